// File: doc/BRIEF.md
# Dual Mode-Selectable Timer Pair

This block holds two 8-bit-per-half timers and the two byte-wide control registers that steer them: a run/flag register and a mode register. Software loads any of the six registers through a write port (address, data, enable). On every cycle where the machine-cycle `tick` is high, each enabled timer advances by one. When a timer wraps, it sets an overflow flag in the run/flag register. An interrupt controller downstream can clear each flag with a one-cycle strobe.

Each timer has four counting modes:
- a 13-bit prescaled count,
- a 16-bit count,
- an 8-bit count that reloads from the high half,
- a split mode.

In split mode, timer 0 becomes two independent 8-bit counters. Its high half uses timer 1's run bit and overflow flag. Timer 1 in that same mode simply freezes. The gate and external-count options in the mode register only inhibit counting here. No pin input exists.

Top module: `tmr_pair`

## Requirements
- R1: A synchronous active-high reset clears all six registers to zero, and all outputs read zero on the next cycle.
- R2: Register addresses are: 0 run/flag, 1 mode, 2 timer 0 low, 3 timer 0 high, 4 timer 1 low, 5 timer 1 high. A write lands one cycle after it is presented. Writes to addresses 6 and 7 change nothing.
- R3: A timer advances only on a cycle with `tick` high, its run bit set and its gate and external-count bits both clear. The run bits are bit 4 for timer 0 and bit 6 for timer 1. In the mode register, timer 0 uses bits 3:0 and timer 1 uses bits 7:4; within each nibble, bit 3 is gate, bit 2 is external-count and bits 1:0 are the mode.
- R4: Mode 0 counts the 13-bit value {high[7:0], low[4:0]}. Low[7:5] is left unchanged. When the value wraps to zero, the timer's flag is set: bit 5 for timer 0, bit 7 for timer 1.
- R5: Mode 1 counts the 16-bit value {high, low} and sets the flag when it wraps to zero.
- R6: Mode 2 increments only the low half. When it overflows, the low half is loaded from the high half and the flag is set.
- R7: With timer 0 in mode 3, its low half counts under the timer 0 enable and sets bit 5. Its high half counts under bit 6 alone, ignoring timer 0's gate and external-count bits, and sets bit 7.
- R8: Timer 1 in mode 3 holds both halves even while running and ticking.
- R9: A register write in the same cycle as a tick takes priority for that register. The other registers still take their tick update, and a carry from a written low half is still computed from its old value.
- R10: A flag is set only by a wrap and is cleared by `clr_ovf[0]` (bit 5) or `clr_ovf[1]` (bit 7). A wrap in the same cycle as a clear strobe leaves the flag set. A write to the run/flag register wins over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Machine-cycle advance strobe |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| clr_ovf | input | 2 | Per-timer flag clear strobes (bit 0: timer 0, bit 1: timer 1) |
| ctl_q | output | 8 | Run/flag register |
| mode_q | output | 8 | Mode register |
| t0_lo | output | 8 | Timer 0 low half |
| t0_hi | output | 8 | Timer 0 high half |
| t1_lo | output | 8 | Timer 1 low half |
| t1_hi | output | 8 | Timer 1 high half |

## Verification
The bench builds the block with its default parameters: 8-bit halves and a 5-bit prescaler field, which gives a 13-bit mode 0 count. Because every counter can be preloaded through the write port, each wrap in each mode is reached in one to five ticks. This covers the 13-bit, 16-bit, reload and split wraps, including the cross-timer flag from timer 0's high half. Directed cases then collide writes, ticks and clear strobes in the same cycle to pin down the priority order.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;

  typedef enum logic [1:0] {
    TM_PRE13   = 2'd0,
    TM_FULL16  = 2'd1,
    TM_RELOAD8 = 2'd2,
    TM_SPLIT   = 2'd3
  } tmr_mode_e;

  // Each timer owns one nibble of the mode register.
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned CT_OFS  = 2;
  localparam int unsigned GT_OFS  = 3;
  // Run/flag register: timer g run bit at 4+2g, flag at 5+2g.
  localparam int unsigned RUN_BASE = 4;

  function automatic int unsigned run_pos(input int unsigned g);
    return RUN_BASE + 2 * g;
  endfunction

  function automatic int unsigned ovf_pos(input int unsigned g);
    return RUN_BASE + 2 * g + 1;
  endfunction

endpackage

// File: rtl/tmr_pair_wdec.sv
module tmr_pair_wdec #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned NREG   = 6
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NREG-1:0]   sel_o
);

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign sel_o[i] = wr_en_i && (addr_i == ADDR_W'(i));
  end

endmodule

// File: rtl/tmr_pair_step.sv
module tmr_pair_step
  import tmr_pair_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PRE_W = 5,
  parameter bit          SPLIT = 1'b0
) (
  input  tmr_mode_e        mode_i,
  input  logic             en_i,
  input  logic             hi_en_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  output logic [CNT_W-1:0] lo_o,
  output logic [CNT_W-1:0] hi_o,
  output logic             ovf_o,
  output logic             ovf_x_o
);

  localparam int unsigned W13 = CNT_W + PRE_W;
  localparam int unsigned W16 = 2 * CNT_W;
  localparam logic [W13:0]   ONE_P = (W13 + 1)'(1);
  localparam logic [W16:0]   ONE_F = (W16 + 1)'(1);
  localparam logic [CNT_W:0] ONE_B = (CNT_W + 1)'(1);

  logic [W13:0]   s13;
  logic [W16:0]   s16;
  logic [CNT_W:0] s_lo;
  logic [CNT_W:0] s_hi;

  assign s13  = {1'b0, hi_i, lo_i[PRE_W-1:0]} + ONE_P;
  assign s16  = {1'b0, hi_i, lo_i} + ONE_F;
  assign s_lo = {1'b0, lo_i} + ONE_B;
  assign s_hi = {1'b0, hi_i} + ONE_B;

  // Split-mode results exist only for the timer that can split.
  logic [CNT_W-1:0] sp_lo, sp_hi;
  logic             sp_ov, sp_ovx;

  if (SPLIT) begin : g_split
    assign sp_lo  = en_i    ? s_lo[CNT_W-1:0] : lo_i;
    assign sp_ov  = en_i    & s_lo[CNT_W];
    assign sp_hi  = hi_en_i ? s_hi[CNT_W-1:0] : hi_i;
    assign sp_ovx = hi_en_i & s_hi[CNT_W];
  end else begin : g_hold
    assign sp_lo  = lo_i;
    assign sp_hi  = hi_i;
    assign sp_ov  = 1'b0;
    assign sp_ovx = 1'b0;
  end

  always_comb begin
    lo_o    = lo_i;
    hi_o    = hi_i;
    ovf_o   = 1'b0;
    ovf_x_o = 1'b0;
    unique case (mode_i)
      TM_PRE13: if (en_i) begin
        {hi_o, lo_o[PRE_W-1:0]} = s13[W13-1:0];
        ovf_o = s13[W13];
      end
      TM_FULL16: if (en_i) begin
        {hi_o, lo_o} = s16[W16-1:0];
        ovf_o = s16[W16];
      end
      TM_RELOAD8: if (en_i) begin
        lo_o  = s_lo[CNT_W] ? hi_i : s_lo[CNT_W-1:0];
        ovf_o = s_lo[CNT_W];
      end
      TM_SPLIT: begin
        lo_o    = sp_lo;
        hi_o    = sp_hi;
        ovf_o   = sp_ov;
        ovf_x_o = sp_ovx;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pair_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned PRE_W  = 5,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [1:0]        clr_ovf,
  output logic [CNT_W-1:0]  ctl_q,
  output logic [CNT_W-1:0]  mode_q,
  output logic [CNT_W-1:0]  t0_lo,
  output logic [CNT_W-1:0]  t0_hi,
  output logic [CNT_W-1:0]  t1_lo,
  output logic [CNT_W-1:0]  t1_hi
);

  localparam int unsigned NTMR    = 2;
  localparam int unsigned NREG    = 2 + 2 * NTMR;
  localparam int unsigned ADR_CTL = 0;
  localparam int unsigned ADR_MOD = 1;

  logic [NREG-1:0]           sel;
  logic [CNT_W-1:0]          ctl_r, ctl_n, mod_r;
  logic [NTMR-1:0][CNT_W-1:0] lo_r, hi_r;
  logic [NTMR-1:0]           ovf_own, ovf_x, hw_set;

  tmr_pair_wdec #(.ADDR_W(ADDR_W), .NREG(NREG)) u_wdec (
    .wr_en_i (wr_en),
    .addr_i  (wr_addr),
    .sel_o   (sel)
  );

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    localparam int unsigned ADR_LO = 2 + 2 * g;
    localparam int unsigned ADR_HI = 3 + 2 * g;

    logic [CNT_W-1:0] lo_q, hi_q, lo_d, hi_d;
    logic             en;

    assign en = ctl_r[run_pos(g)]
              & ~mod_r[g*NIB_W + CT_OFS]
              & ~mod_r[g*NIB_W + GT_OFS];

    tmr_pair_step #(.CNT_W(CNT_W), .PRE_W(PRE_W), .SPLIT(g == 0)) u_step (
      .mode_i  (tmr_mode_e'(mod_r[g*NIB_W +: 2])),
      .en_i    (en),
      .hi_en_i (ctl_r[run_pos(1)]),
      .lo_i    (lo_q),
      .hi_i    (hi_q),
      .lo_o    (lo_d),
      .hi_o    (hi_d),
      .ovf_o   (ovf_own[g]),
      .ovf_x_o (ovf_x[g])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        if (sel[ADR_LO])   lo_q <= wr_data;
        else if (tick)     lo_q <= lo_d;
        if (sel[ADR_HI])   hi_q <= wr_data;
        else if (tick)     hi_q <= hi_d;
      end
    end

    assign lo_r[g] = lo_q;
    assign hi_r[g] = hi_q;
  end

  // Timer 0's split high half raises timer 1's flag.
  assign hw_set[0] = tick & ovf_own[0];
  assign hw_set[1] = tick & (ovf_own[1] | ovf_x[0]);

  always_comb begin
    ctl_n = ctl_r;
    for (int g = 0; g < NTMR; g++) begin
      if (clr_ovf[g]) ctl_n[ovf_pos(g)] = 1'b0;
      if (hw_set[g])  ctl_n[ovf_pos(g)] = 1'b1;
    end
    if (sel[ADR_CTL]) ctl_n = wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_r <= '0;
      mod_r <= '0;
    end else begin
      ctl_r <= ctl_n;
      if (sel[ADR_MOD]) mod_r <= wr_data;
    end
  end

  assign ctl_q  = ctl_r;
  assign mode_q = mod_r;
  assign t0_lo  = lo_r[0];
  assign t0_hi  = hi_r[0];
  assign t1_lo  = lo_r[1];
  assign t1_hi  = hi_r[1];

endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CNT_W-1:0]  wr_data,
  input logic [1:0]        clr_ovf,
  input logic [CNT_W-1:0]  ctl_q,
  input logic [CNT_W-1:0]  mode_q,
  input logic [CNT_W-1:0]  t0_lo,
  input logic [CNT_W-1:0]  t0_hi,
  input logic [CNT_W-1:0]  t1_lo,
  input logic [CNT_W-1:0]  t1_hi
);

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (ctl_q == '0 && mode_q == '0 && t0_lo == '0 && t0_hi == '0
             && t1_lo == '0 && t1_hi == '0));

  // R2
  mode_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(1)) |=> mode_q == $past(wr_data));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_en) |=> ($stable(t0_lo) && $stable(t0_hi)
                           && $stable(t1_lo) && $stable(t1_hi)));

  // R8
  t1_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en && mode_q[5:4] == 2'b11) |=> $stable({t1_hi, t1_lo}));

  // R10
  flag_src_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !(wr_en && wr_addr == '0)) |=> (!$rose(ctl_q[5]) && !$rose(ctl_q[7])));

  // R10
  flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_ovf[0] && !tick && !wr_en) |=> !ctl_q[5]);

endmodule

bind tmr_pair tmr_pair_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .clr_ovf(clr_ovf), .ctl_q(ctl_q), .mode_q(mode_q),
  .t0_lo(t0_lo), .t0_hi(t0_hi), .t1_lo(t1_lo), .t1_hi(t1_hi)
);

// File: tb/tmr_pair_tb.sv
module tmr_pair_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] clr_ovf = '0;
  logic [7:0] ctl_q, mode_q, t0_lo, t0_hi, t1_lo, t1_hi;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tmr_pair u_dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .clr_ovf(clr_ovf), .ctl_q(ctl_q), .mode_q(mode_q),
    .t0_lo(t0_lo), .t0_hi(t0_hi), .t1_lo(t1_lo), .t1_hi(t1_hi)
  );

  // {req, tsel, mode, ctl, lo, hi, ticks, exp_lo, exp_hi, exp_ctl}
  localparam int NV = 14;
  localparam logic [79:0] VEC [NV] = '{
    80'h05_00_01_10_FE_FF_03_01_00_30, // R5 16-bit wrap
    80'h05_00_01_10_10_12_05_15_12_10, // R5 plain count
    80'h04_00_00_10_FE_FF_03_E1_00_30, // R4 13-bit wrap, low[7:5] kept
    80'h04_00_00_10_1F_03_01_00_04_10, // R4 prescale carry
    80'h06_00_02_10_FD_80_04_81_80_30, // R6 reload
    80'h03_00_09_10_05_00_04_05_00_10, // R3 gate set
    80'h03_00_05_10_05_00_04_05_00_10, // R3 external-count set
    80'h03_00_01_00_05_00_04_05_00_00, // R3 run clear
    80'h07_00_33_50_FE_FF_02_00_01_F0, // R7 split both halves
    80'h07_00_3B_50_10_FE_03_10_01_D0, // R7 split, gate stops low only
    80'h08_01_30_40_12_34_04_12_34_40, // R8 timer 1 frozen
    80'h05_01_10_40_FF_FF_01_00_00_C0, // R5 timer 1 wrap
    80'h06_01_20_40_FF_33_02_34_33_C0, // R6 timer 1 reload
    80'h04_01_00_40_25_00_03_28_00_40  // R4 timer 1 prescale
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %02h exp %02h", req, got, exp);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] a, input logic [7:0] d,
                      input logic tk, input logic [1:0] cl);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; tick = tk; clr_ovf = cl;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0; clr_ovf = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0, 2'b00);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 ctl", ctl_q, 8'h00);   chk("R1 mode", mode_q, 8'h00);
    chk("R1 t0lo", t0_lo, 8'h00);  chk("R1 t0hi", t0_hi, 8'h00);
    chk("R1 t1lo", t1_lo, 8'h00);  chk("R1 t1hi", t1_hi, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [79:0] v;
      logic [2:0]  alo;
      string       tag;
      v   = VEC[i];
      alo = (v[71:64] != 8'h00) ? 3'd4 : 3'd2;
      tag = $sformatf("R%0d vec%0d", v[79:72], i);
      wr(3'd0, 8'h00);
      wr(3'd1, v[63:56]);
      wr(alo, v[47:40]);
      wr(alo + 3'd1, v[39:32]);
      wr(3'd0, v[55:48]);
      for (int t = 0; t < int'(v[31:24]); t++) step(1'b0, 3'd0, 8'h00, 1'b1, 2'b00);
      chk({tag, " lo"}, (alo == 3'd4) ? t1_lo : t0_lo, v[23:16]);
      chk({tag, " hi"}, (alo == 3'd4) ? t1_hi : t0_hi, v[15:8]);
      chk({tag, " ctl"}, ctl_q, v[7:0]);
    end

    do_reset();
    chk("R1 after second reset", t1_lo, 8'h00);

    // R9 write beats tick for the written byte only
    wr(3'd1, 8'h01); wr(3'd2, 8'h10); wr(3'd3, 8'h20); wr(3'd0, 8'h10);
    step(1'b1, 3'd2, 8'h80, 1'b1, 2'b00);
    chk("R9 lo written", t0_lo, 8'h80);
    chk("R9 hi ticked", t0_hi, 8'h20);
    wr(3'd2, 8'hFF); wr(3'd3, 8'h00);
    step(1'b1, 3'd3, 8'h55, 1'b1, 2'b00);
    chk("R9 lo carry", t0_lo, 8'h00);
    chk("R9 hi written", t0_hi, 8'h55);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    step(1'b1, 3'd0, 8'h10, 1'b1, 2'b00);
    chk("R10 ctl write beats wrap", ctl_q, 8'h10);
    chk("R9 wrap lo", t0_lo, 8'h00);

    // R10 strobe clears, wrap beats strobe
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    step(1'b0, 3'd0, 8'h00, 1'b1, 2'b00);
    chk("R10 flag set", ctl_q, 8'h30);
    step(1'b0, 3'd0, 8'h00, 1'b0, 2'b01);
    chk("R10 strobe clears", ctl_q, 8'h10);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    step(1'b0, 3'd0, 8'h00, 1'b1, 2'b01);
    chk("R10 wrap beats strobe", ctl_q, 8'h30);
    wr(3'd0, 8'hB0);
    step(1'b0, 3'd0, 8'h00, 1'b0, 2'b01);
    chk("R10 strobe 0 keeps bit 7", ctl_q, 8'h90);
    step(1'b0, 3'd0, 8'h00, 1'b0, 2'b10);
    chk("R10 strobe 1 clears bit 7", ctl_q, 8'h10);

    // R2 unused addresses
    wr(3'd6, 8'hAA); wr(3'd7, 8'hAA);
    chk("R2 ctl", ctl_q, 8'h10);   chk("R2 mode", mode_q, 8'h01);
    chk("R2 t0lo", t0_lo, 8'h00);  chk("R2 t0hi", t0_hi, 8'h00);
    chk("R2 t1lo", t1_lo, 8'h00);  chk("R2 t1hi", t1_hi, 8'h00);

    // R3 no tick, no count
    wr(3'd2, 8'h40);
    repeat (5) @(negedge clk);
    chk("R3 idle hold", t0_lo, 8'h40);

    finish_run();
  end

endmodule